// File: doc/BRIEF.md
# RDS Block Synchronization Controller

This controller follows the block-level synchronization of a radio data system decoder that has just been retuned and needs the programme identification code quickly. For every received 26-bit block an upstream syndrome stage supplies one result strobe. The strobe carries the offset type of the block and two quality flags: error-free, and repaired by error correction. The controller decides whether the decoder is locked to the block cycle. While it is still searching, it already reports error-free A and C' blocks, so the host can read the programme code before lock is declared.

Lock is declared when two error-free blocks arrive whose positions fit the cyclic block order, counting any bad blocks that fell between them. The number of bad blocks tolerated is set by a 2-bit input. Every reported block raises a data-available flag and pulls an active-low interrupt. It also moves the previously latched block identity into a history register before latching the new one. A host read strobe clears the flag and releases the interrupt.

Top module: `rds_sync_ctrl`

## Requirements
- R1: After reset `in_sync`=0, `dav`=0, `irq_n`=1, and both `last_blk` and `prev_blk` hold the unknown code 3'b111.
- R2: Block type codes are A=0, B=1, C=2, C'=3 and D=4. Cyclic positions are A=0, B=1, C and C'=2, D=3. Codes 5 to 7 count as bad blocks.
- R3: While unsynchronized, an error-free A or C' block is reported one cycle after its strobe: `dav`=1, `irq_n`=0, `prev_blk` takes the old `last_blk`, and `last_blk` takes the type. No other block is reported before lock.
- R4: While unsynchronized, an error-free block becomes the anchor when no anchor is held. A following error-free block whose position equals (anchor position + bad blocks since the anchor + 1) mod 4 sets `in_sync`=1, and that block is reported.
- R5: While unsynchronized, an error-free block that does not fit the expected position replaces the anchor, and its bad count restarts at 0.
- R6: Let the limit L be `bad_tol`, or 1 when `bad_tol` is 0. A bad block that brings the count since the anchor up to L drops the anchor, so a later good block is taken as a new anchor. With `bad_tol`=3, up to 2 bad blocks may lie between the two good blocks.
- R7: Before lock only `blk_ok` makes a block good. A block that only has `blk_fixed` set is bad there, whatever `fix_en` says.
- R8: Once `in_sync` is 1 it stays 1 until reset. Every block with a known type is then reported if `blk_ok` is set, or if both `blk_fixed` and `fix_en` are set. All other blocks leave the outputs unchanged.
- R9: `host_rd` clears `dav` and raises `irq_n` on the next cycle. If a block is reported in the same cycle, the report wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_valid | input | 1 | One-cycle strobe per received block |
| blk_type | input | 3 | Detected offset type code |
| blk_ok | input | 1 | Block has no errors |
| blk_fixed | input | 1 | Block was repaired by error correction |
| fix_en | input | 1 | Accept repaired blocks once synchronized |
| bad_tol | input | 2 | Bad-block tolerance between the two good blocks |
| host_rd | input | 1 | Host read of the last-block register |
| dav | output | 1 | Data-available flag |
| irq_n | output | 1 | Active-low interrupt |
| in_sync | output | 1 | Synchronization status |
| last_blk | output | 3 | Type of the most recently reported block |
| prev_blk | output | 3 | Type of the block reported before it |

## Verification
The anchor position and the bad-block count are hidden state. A wrong value in either shows up at the ports in one of two ways: `in_sync` rises one cycle after a block that should not have locked, or it stays low after a block that should have. The bench therefore drives gap sequences of 0 to 3 bad blocks at every tolerance setting and compares all five outputs against a reference model after each strobe. A stale history register or a wrong clear-versus-set priority appears one cycle after the strobe, on `prev_blk` or `dav`.

// File: rtl/rds_sync_ctrl.sv
`timescale 1ns/1ps
module rds_sync_ctrl #(
  parameter logic [2:0] UNK_CODE = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_valid,
  input  logic [2:0] blk_type,
  input  logic       blk_ok,
  input  logic       blk_fixed,
  input  logic       fix_en,
  input  logic [1:0] bad_tol,
  input  logic       host_rd,
  output logic       dav,
  output logic       irq_n,
  output logic       in_sync,
  output logic [2:0] last_blk,
  output logic [2:0] prev_blk
);
  localparam logic [2:0] TY_A = 3'd0, TY_B = 3'd1, TY_C = 3'd2, TY_CP = 3'd3, TY_D = 3'd4;

  logic       anchored;
  logic [1:0] anc_pos, bad_cnt;
  logic [1:0] pos;

  always_comb begin
    unique case (blk_type)
      TY_A:        pos = 2'd0;
      TY_B:        pos = 2'd1;
      TY_C, TY_CP: pos = 2'd2;
      default:     pos = 2'd3;
    endcase
  end

  wire       known   = blk_type <= TY_D;
  wire       good    = blk_valid & blk_ok & known;
  wire       bad     = blk_valid & ~good;
  wire [1:0] want    = anc_pos + bad_cnt + 2'd1;
  wire [1:0] limit   = (bad_tol == 2'd0) ? 2'd1 : bad_tol;
  wire       hit     = ~in_sync & anchored & good & (pos == want);
  wire       give_up = ~in_sync & anchored & bad & (({1'b0, bad_cnt} + 3'd1) >= {1'b0, limit});
  wire       acc     = in_sync & blk_valid & known & (blk_ok | (fix_en & blk_fixed));
  wire       ac_blk  = (blk_type == TY_A) | (blk_type == TY_CP);
  wire       report  = acc | hit | (~in_sync & good & ac_blk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sync  <= 1'b0;
      anchored <= 1'b0;
      anc_pos  <= 2'd0;
      bad_cnt  <= 2'd0;
    end else if (!in_sync) begin
      if (hit) begin
        in_sync  <= 1'b1;
        anchored <= 1'b0;
        bad_cnt  <= 2'd0;
      end else if (good) begin
        anchored <= 1'b1;
        anc_pos  <= pos;
        bad_cnt  <= 2'd0;
      end else if (give_up) begin
        anchored <= 1'b0;
        bad_cnt  <= 2'd0;
      end else if (bad && anchored) begin
        bad_cnt  <= bad_cnt + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav      <= 1'b0;
      irq_n    <= 1'b1;
      last_blk <= UNK_CODE;
      prev_blk <= UNK_CODE;
    end else if (report) begin
      dav      <= 1'b1;
      irq_n    <= 1'b0;
      last_blk <= blk_type;
      prev_blk <= last_blk;
    end else if (host_rd) begin
      dav      <= 1'b0;
      irq_n    <= 1'b1;
    end
  end
endmodule

// File: rtl/rds_sync_ctrl_chk.sv
`timescale 1ns/1ps
module rds_sync_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       blk_valid,
  input logic       blk_ok,
  input logic       host_rd,
  input logic       dav,
  input logic       irq_n,
  input logic       in_sync,
  input logic [2:0] last_blk,
  input logic [2:0] prev_blk
);
  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) in_sync |=> in_sync); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (host_rd && !blk_valid) |=> (!dav && irq_n)); // R9
  AST_LOCK_REPORTS: assert property (@(posedge clk) disable iff (!rst_n) $rose(in_sync) |-> (dav && !irq_n)); // R4
  AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_n) |-> (prev_blk == $past(last_blk))); // R3
  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (!in_sync && blk_valid && !blk_ok) |=> $stable(last_blk)); // R7
endmodule

bind rds_sync_ctrl rds_sync_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ok(blk_ok), .host_rd(host_rd),
  .dav(dav), .irq_n(irq_n), .in_sync(in_sync), .last_blk(last_blk), .prev_blk(prev_blk)
);

// File: tb/rds_sync_ctrl_bench.sv
`timescale 1ns/1ps
module rds_sync_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic blk_valid = 0, blk_ok = 0, blk_fixed = 0, fix_en = 0, host_rd = 0;
  logic [2:0] blk_type = 0;
  logic [1:0] bad_tol = 0;
  logic dav, irq_n, in_sync;
  logic [2:0] last_blk, prev_blk;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  rds_sync_ctrl u_rds_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_type(blk_type), .blk_ok(blk_ok),
    .blk_fixed(blk_fixed), .fix_en(fix_en), .bad_tol(bad_tol), .host_rd(host_rd),
    .dav(dav), .irq_n(irq_n), .in_sync(in_sync), .last_blk(last_blk), .prev_blk(prev_blk)
  );

  logic m_sync, m_dav, m_irqn, m_anc;
  logic [2:0] m_last, m_prev;
  logic [1:0] m_apos;
  int m_bad;

  function automatic logic [1:0] pos_f(logic [2:0] t);
    return (t == 3'd0) ? 2'd0 : (t == 3'd1) ? 2'd1 : (t == 3'd4) ? 2'd3 : 2'd2;
  endfunction

  task automatic model_reset();
    m_sync = 0; m_dav = 0; m_irqn = 1; m_anc = 0; m_last = 3'b111; m_prev = 3'b111; m_apos = 0; m_bad = 0;
  endtask

  task automatic model_step(logic v, logic [2:0] t, logic ok, logic fx, logic rd);
    logic good, rep, match;
    int lim;
    good = v && ok && (t <= 3'd4);
    lim = (bad_tol == 0) ? 1 : int'(bad_tol);
    rep = 0;
    if (m_sync) begin
      rep = v && (t <= 3'd4) && (ok || (fix_en && fx));
    end else if (good) begin
      match = m_anc && (pos_f(t) == 2'(int'(m_apos) + m_bad + 1));
      rep = match || t == 3'd0 || t == 3'd3;
      if (match) begin m_sync = 1; m_anc = 0; m_bad = 0; end
      else begin m_anc = 1; m_apos = pos_f(t); m_bad = 0; end
    end else if (v && m_anc) begin
      m_bad++;
      if (m_bad >= lim) begin m_anc = 0; m_bad = 0; end
    end
    if (rep) begin m_dav = 1; m_irqn = 0; m_prev = m_last; m_last = t; end
    else if (rd) begin m_dav = 0; m_irqn = 1; end
  endtask

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act sync/dav/irqn/last/prev=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] st();
    return {in_sync, dav, irq_n, last_blk, prev_blk};
  endfunction

  task automatic expect_st(string tag, logic s, logic d, logic i, logic [2:0] l, logic [2:0] p);
    chk(tag, st(), {s, d, i, l, p});
  endtask

  task automatic step(logic v, logic [2:0] t, logic ok, logic fx, logic rd);
    blk_valid = v; blk_type = t; blk_ok = ok; blk_fixed = fx; host_rd = rd;
    @(posedge clk);
    model_step(v, t, ok, fx, rd);
    @(negedge clk);
    blk_valid = 0; blk_ok = 0; blk_fixed = 0; host_rd = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bad_tol = 3;
    do_reset();
    expect_st("R1", 0, 0, 1, 3'b111, 3'b111);
    step(1, 0, 1, 0, 0); expect_st("R3", 0, 1, 0, 0, 7);
    step(0, 0, 0, 0, 1); expect_st("R9", 0, 0, 1, 0, 7);
    step(1, 2, 1, 0, 0); expect_st("R5", 0, 0, 1, 0, 7);
    step(1, 4, 1, 0, 0); expect_st("R4", 1, 1, 0, 4, 0);

    do_reset();
    step(1, 0, 1, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(1, 4, 1, 0, 0); expect_st("R6", 1, 1, 0, 4, 0);

    do_reset();
    step(1, 0, 1, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 2, 0, 0, 0);
    step(1, 4, 1, 0, 0); expect_st("R6", 0, 1, 0, 0, 7);
    step(1, 0, 1, 0, 0); expect_st("R6", 1, 1, 0, 0, 0);

    bad_tol = 0;
    do_reset();
    step(1, 0, 1, 0, 0); step(0, 0, 0, 0, 1); step(1, 6, 1, 0, 0);
    step(1, 1, 1, 0, 0); expect_st("R6", 0, 0, 1, 0, 7);

    bad_tol = 3; fix_en = 1;
    do_reset();
    step(1, 0, 0, 1, 0); expect_st("R7", 0, 0, 1, 7, 7);
    step(1, 0, 1, 0, 0); step(1, 1, 0, 1, 0); expect_st("R7", 0, 1, 0, 0, 7);
    step(1, 2, 1, 0, 0); expect_st("R4", 1, 1, 0, 2, 0);
    step(1, 4, 1, 0, 1); expect_st("R9", 1, 1, 0, 4, 2);
    step(1, 4, 0, 1, 0); expect_st("R8", 1, 1, 0, 4, 4);
    step(1, 6, 1, 0, 0); expect_st("R2", 1, 1, 0, 4, 4);
    step(0, 0, 0, 0, 1); expect_st("R9", 1, 0, 1, 4, 4);
    step(1, 1, 0, 0, 0); expect_st("R8", 1, 0, 1, 4, 4);
    fix_en = 0;
    step(1, 1, 0, 1, 0); expect_st("R8", 1, 0, 1, 4, 4);

    do_reset();
    step(1, 3, 1, 0, 0); expect_st("R3", 0, 1, 0, 3, 7);
    step(1, 1, 1, 0, 0); expect_st("R5", 0, 1, 0, 3, 7);
    step(1, 2, 1, 0, 0); expect_st("R4", 1, 1, 0, 2, 3);

    void'($urandom(32'd1234));
    for (int ep = 0; ep < 60; ep++) begin
      bad_tol = 2'($urandom_range(0, 3));
      fix_en = 1'($urandom_range(0, 1));
      do_reset();
      for (int n = 0; n < 40; n++) begin
        logic v, ok, fx, rd;
        logic [2:0] t;
        v  = ($urandom_range(0, 9) < 8);
        t  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
        ok = ($urandom_range(0, 9) < 6);
        fx = 1'($urandom_range(0, 1));
        rd = ($urandom_range(0, 4) == 0);
        step(v, t, ok, fx, rd);
        chk(rd ? "R9" : (m_sync ? "R8" : "R4"), st(),
            {m_sync, m_dav, m_irqn, m_last, m_prev});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule